// File: doc/BRIEF.md
# Debug Register Save/Restore Controller

This block is an APB slave that owns a small bank of debug configuration words. An operating system can copy the bank out before the core loses power and copy it back in afterwards. Both directions go through a single data-port address, one word per access. The OS first writes a fixed key to a lock register. The first data-port read then reports how many words follow, and each later read streams the next word. On restore, the first write must state that same count, and later writes refill the bank in the same order.

Two mechanisms let an external debugger notice the gap in its session. While the lock is engaged, unprivileged accesses to the bank get a slave error. Privileged accesses from the OS side pass. A power-down event sets a sticky flag. Until software reads the status register, that flag makes every unprivileged mapped access other than the status read fail. While the core is held powered off, every mapped access fails, whoever issues it. The block never inserts wait states.

Top module: `dbgsr_top`

## Requirements
- R1: After reset the lock and sticky flag are clear, every bank word reads zero, and `pready` is 1 in every access cycle.
- R2: A write to offset 0x300 of exactly 0xC5ACCE55 engages the lock, and a write of any other value releases it. A read of 0x300 returns the lock state in bit 0.
- R3: After the lock is engaged, the first read of the data port at offset 0x308 returns the bank size (NREG).
- R4: Each later data-port read returns bank word 0, then 1, up to NREG-1, at offsets 0x000, 0x004 and upward. Once all words are out, further reads return zero.
- R5: On restore, a data-port write at the count step advances only if the value equals NREG; otherwise nothing changes. The NREG writes after that load bank words 0 to NREG-1 in order, and any further writes are ignored.
- R6: While locked, an unprivileged (`ppriv`=0) bank access gets `pslverr` with read data zero, and a write does not change the bank. Privileged accesses to the bank still work.
- R7: While `core_off` is 1, every mapped access errors for any requester and has no side effect.
- R8: A `pdn_pulse` sets the sticky flag. While it is set, unprivileged accesses to the bank, lock and data port error and have no effect. A successful read of the status register at 0x314 returns sticky in bit 0 and lock in bit 1, and clears the sticky flag.
- R9: An access to an unmapped offset reads zero and never errors.
- R10: Any write to the lock register, key or not, returns the sequencer to its count step.
- R11: While unlocked, data-port reads return zero and data-port writes change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | AW | APB byte address |
| pwdata | input | DW | APB write data |
| ppriv | input | 1 | Access comes from the privileged OS side |
| core_off | input | 1 | Core is currently powered down |
| pdn_pulse | input | 1 | One-cycle power-down event |
| prdata | output | DW | APB read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | APB slave error |

## Verification
The bench streams the bank out and checks the leading count, the word order and the zero reads once all words are out. A sequencer that is off by one would shift every word or repeat the count. On restore, the bench writes wrong counts before the right one. A design that skips the count check would load the wrong value into word 0. The bench also checks that a second write with the key returns the port to the count step. It then tests blocked accesses while locked, sticky or powered off and reads the bank back afterwards. A design that blocked the response but still applied the write would show the corrupted word. Finally, a status read clears the sticky flag, and a later debugger access confirms the flag is gone.

// File: rtl/dbgsr_pkg.sv
package dbgsr_pkg;
  localparam logic [31:0] LOCK_KEY = 32'hC5ACCE55;
  localparam int OFS_LOCK = 'h300;
  localparam int OFS_PORT = 'h308;
  localparam int OFS_STAT = 'h314;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_BANK,
    RG_LOCK,
    RG_PORT,
    RG_STAT
  } region_e;
endpackage

// File: rtl/dbgsr_decode.sv
module dbgsr_decode
  import dbgsr_pkg::*;
#(
  parameter int AW   = 12,
  parameter int NREG = 4,
  parameter int IW   = 2
) (
  input  logic [AW-1:0] addr,
  output region_e       region,
  output logic [IW-1:0] idx
);
  always_comb begin
    region = RG_NONE;
    if (addr < AW'(4 * NREG))        region = RG_BANK;
    else if (addr == AW'(OFS_LOCK))  region = RG_LOCK;
    else if (addr == AW'(OFS_PORT))  region = RG_PORT;
    else if (addr == AW'(OFS_STAT))  region = RG_STAT;
  end

  assign idx = addr[IW+1:2];
endmodule

// File: rtl/dbgsr_bank.sv
module dbgsr_bank #(
  parameter int DW   = 32,
  parameter int NREG = 4,
  parameter int IW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/dbgsr_seq.sv
module dbgsr_seq #(
  parameter int NREG = 4,
  parameter int IW   = 2,
  parameter int PW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          rd_step,
  input  logic          wr_step,
  input  logic          count_ok,
  output logic          at_count,
  output logic          done,
  output logic [IW-1:0] widx
);
  localparam logic [PW-1:0] LAST = PW'(NREG);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic [PW-1:0] ptr;
  logic [PW-1:0] ptr_m1;

  assign at_count = (ptr == '0);
  assign done     = (ptr > LAST);
  assign ptr_m1   = ptr - ONE;
  assign widx     = ptr_m1[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ptr <= '0;
    end else if (rd_step && !done) begin
      ptr <= ptr + ONE;
    end else if (wr_step && at_count) begin
      if (count_ok) ptr <= ONE;
    end else if (wr_step && !done) begin
      ptr <= ptr + ONE;
    end
  end
endmodule

// File: rtl/dbgsr_top.sv
module dbgsr_top
  import dbgsr_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int NREG = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  input  logic          ppriv,
  input  logic          core_off,
  input  logic          pdn_pulse,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int PW = $clog2(NREG + 2);

  region_e       region;
  logic [IW-1:0] bidx;
  logic [IW-1:0] seq_idx;
  logic          at_count, done;
  logic          locked_q, sticky_q;
  logic          resp_err_q;
  logic [DW-1:0] resp_data_q;
  logic [DW-1:0] bank_rd_a, bank_rd_b;
  logic          setup_ph, access_ph, ok_acc;
  logic          lock_wr, port_rd, port_wr, stat_rd, bank_wr;
  logic          bank_we;
  logic [IW-1:0] bank_waddr;
  logic          err_now;
  logic [DW-1:0] rd_now;

  dbgsr_decode #(.AW(AW), .NREG(NREG), .IW(IW)) u_dec (
    .addr(paddr), .region(region), .idx(bidx)
  );

  assign setup_ph  = psel & ~penable;
  assign access_ph = psel & penable;
  assign ok_acc    = access_ph & ~resp_err_q;
  assign lock_wr   = ok_acc & pwrite & (region == RG_LOCK);
  assign port_rd   = ok_acc & ~pwrite & (region == RG_PORT) & locked_q;
  assign port_wr   = ok_acc & pwrite & (region == RG_PORT) & locked_q;
  assign stat_rd   = ok_acc & ~pwrite & (region == RG_STAT);
  assign bank_wr   = ok_acc & pwrite & (region == RG_BANK);

  dbgsr_seq #(.NREG(NREG), .IW(IW), .PW(PW)) u_seq (
    .clk(clk), .rst(rst), .restart(lock_wr),
    .rd_step(port_rd), .wr_step(port_wr),
    .count_ok(pwdata == DW'(NREG)),
    .at_count(at_count), .done(done), .widx(seq_idx)
  );

  assign bank_we    = bank_wr | (port_wr & ~at_count & ~done);
  assign bank_waddr = bank_wr ? bidx : seq_idx;

  dbgsr_bank #(.DW(DW), .NREG(NREG), .IW(IW)) u_bank (
    .clk(clk), .rst(rst), .we(bank_we), .waddr(bank_waddr), .wdata(pwdata),
    .raddr_a(bidx), .rdata_a(bank_rd_a),
    .raddr_b(seq_idx), .rdata_b(bank_rd_b)
  );

  // Access permission, decided in the setup phase
  always_comb begin
    err_now = 1'b0;
    if (region != RG_NONE) begin
      if (core_off) err_now = 1'b1;
      else if (!ppriv && sticky_q && region != RG_STAT) err_now = 1'b1;
      else if (!ppriv && locked_q && region == RG_BANK) err_now = 1'b1;
    end
  end

  always_comb begin
    rd_now = '0;
    case (region)
      RG_BANK: rd_now = bank_rd_a;
      RG_LOCK: rd_now = DW'(locked_q);
      RG_PORT: begin
        if (locked_q) begin
          if (at_count)  rd_now = DW'(NREG);
          else if (!done) rd_now = bank_rd_b;
        end
      end
      RG_STAT: rd_now = DW'({locked_q, sticky_q});
      default: rd_now = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_err_q  <= 1'b0;
      resp_data_q <= '0;
    end else if (setup_ph) begin
      resp_err_q  <= err_now;
      resp_data_q <= (err_now || pwrite) ? '0 : rd_now;
    end else begin
      resp_err_q  <= 1'b0;
      resp_data_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          locked_q <= 1'b0;
    else if (lock_wr) locked_q <= (pwdata == DW'(LOCK_KEY));
  end

  always_ff @(posedge clk) begin
    if (rst)            sticky_q <= 1'b0;
    else if (pdn_pulse) sticky_q <= 1'b1;
    else if (stat_rd)   sticky_q <= 1'b0;
  end

  assign prdata  = resp_data_q;
  assign pslverr = resp_err_q;
  assign pready  = 1'b1;
endmodule

// File: rtl/dbgsr_chk.sv
module dbgsr_chk
  import dbgsr_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int NREG = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [DW-1:0] pwdata,
  input logic          ppriv,
  input logic          core_off,
  input logic          pdn_pulse,
  input logic [DW-1:0] prdata,
  input logic          pslverr,
  input logic          locked,
  input logic          sticky
);
  logic acc, bank_hit, mapped;
  assign acc      = psel & penable;
  assign bank_hit = paddr < AW'(4 * NREG);
  assign mapped   = bank_hit || paddr == AW'(OFS_LOCK) ||
                    paddr == AW'(OFS_PORT) || paddr == AW'(OFS_STAT);

  // R1
  err_only_in_access_chk: assert property (@(posedge clk) disable iff (rst)
    pslverr |-> acc);

  // R2
  lock_follows_key_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && pwrite && paddr == AW'(OFS_LOCK) && !pslverr)
      |=> (locked == ($past(pwdata) == DW'(LOCK_KEY))));

  // R6
  locked_bank_err_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !ppriv && bank_hit && locked) |-> pslverr);

  // R7
  core_off_err_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && mapped && $past(core_off)) |-> pslverr);

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    pdn_pulse |=> sticky);

  // R8
  sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !pwrite && paddr == AW'(OFS_STAT) && !pslverr && !pdn_pulse) |=> !sticky);

  // R9
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !mapped) |-> (!pslverr && prdata == '0));
endmodule

bind dbgsr_top dbgsr_chk #(.AW(AW), .DW(DW), .NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .ppriv(ppriv), .core_off(core_off),
  .pdn_pulse(pdn_pulse), .prdata(prdata), .pslverr(pslverr),
  .locked(locked_q), .sticky(sticky_q)
);

// File: tb/dbgsr_top_tb.sv
module dbgsr_top_tb;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NREG = 4;
  localparam logic [31:0] KEY = 32'hC5ACCE55;
  localparam logic [11:0] A_LOCK = 12'h300, A_PORT = 12'h308, A_STAT = 12'h314;

  logic clk = 0, rst = 1;
  logic psel = 0, penable = 0, pwrite = 0, ppriv = 0, core_off = 0, pdn_pulse = 0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic pready, pslverr;

  int checks = 0, failures = 0;
  logic          q_err[$];
  logic [DW-1:0] q_dat[$];
  string         q_tag[$];

  always #5 clk = ~clk;

  dbgsr_top #(.AW(AW), .DW(DW), .NREG(NREG)) u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .ppriv(ppriv), .core_off(core_off),
    .pdn_pulse(pdn_pulse), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  // Monitor: pops expected results and compares in each access cycle
  always @(negedge clk) begin
    if (!rst && psel && penable) begin
      logic xe; logic [DW-1:0] xd; string tg;
      checks++;
      if (q_err.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty: got err=%0b data=%h expected none", pslverr, prdata);
      end else begin
        xe = q_err.pop_front(); xd = q_dat.pop_front(); tg = q_tag.pop_front();
        if (pslverr !== xe || prdata !== xd || pready !== 1'b1) begin
          failures++;
          $display("FAIL %s: got err=%0b data=%h rdy=%0b expected err=%0b data=%h rdy=1",
                   tg, pslverr, prdata, pready, xe, xd);
        end
      end
    end
  end

  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic pr, input logic xerr, input logic [DW-1:0] xdat,
                      input string tag);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; ppriv = pr;
    q_err.push_back(xerr); q_dat.push_back(xdat); q_tag.push_back(tag);
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0;
  endtask

  task automatic pulse_pdn();
    @(posedge clk); #1 pdn_pulse = 1;
    @(posedge clk); #1 pdn_pulse = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R1 reset state
    xfer(0, A_STAT, 0, 0, 0, 32'h0, "R1 status after reset");
    xfer(0, 12'h000, 0, 0, 0, 32'h0, "R1 bank word0 after reset");

    // fill bank unlocked
    for (int i = 0; i < NREG; i++)
      xfer(1, AW'(4*i), 32'hA000_0000 + i, 0, 0, 32'h0, "R1 bank write");
    xfer(0, 12'h008, 0, 0, 0, 32'hA000_0002, "R1 bank readback");

    // R2 lock
    xfer(0, A_LOCK, 0, 0, 0, 32'h0, "R2 lock clear");
    xfer(1, A_LOCK, KEY, 1, 0, 32'h0, "R2 key write");
    xfer(0, A_LOCK, 0, 1, 0, 32'h1, "R2 lock set");
    xfer(0, A_STAT, 0, 1, 0, 32'h2, "R8 status shows lock in bit1");

    // R6 debugger blocked, OS bypasses
    xfer(0, 12'h004, 0, 0, 1, 32'h0, "R6 debugger read blocked");
    xfer(1, 12'h004, 32'hBAD0_BAD0, 0, 1, 32'h0, "R6 debugger write blocked");
    xfer(0, 12'h004, 0, 1, 0, 32'hA000_0001, "R6 privileged read, write had no effect");

    // R3 / R4 save stream
    xfer(0, A_PORT, 0, 1, 0, NREG, "R3 count word");
    for (int i = 0; i < NREG; i++)
      xfer(0, A_PORT, 0, 1, 0, 32'hA000_0000 + i, "R4 stream word");
    xfer(0, A_PORT, 0, 1, 0, 32'h0, "R4 read past end");

    // R10 rewriting key restarts
    xfer(1, A_LOCK, KEY, 1, 0, 32'h0, "R10 key again");
    xfer(0, A_PORT, 0, 1, 0, NREG, "R10 count again");
    xfer(0, A_PORT, 0, 1, 0, 32'hA000_0000, "R10 first word again");

    // R2 / R11 unlock
    xfer(1, A_LOCK, 32'h1234_5678, 1, 0, 32'h0, "R2 wrong value write");
    xfer(0, A_LOCK, 0, 0, 0, 32'h0, "R2 unlocked");
    xfer(0, A_PORT, 0, 0, 0, 32'h0, "R11 port read unlocked");
    xfer(1, A_PORT, NREG, 0, 0, 32'h0, "R11 port write unlocked");
    xfer(1, A_PORT, 32'h5555_5555, 0, 0, 32'h0, "R11 port write unlocked");
    xfer(0, 12'h000, 0, 0, 0, 32'hA000_0000, "R11 bank untouched");

    // R8 sticky
    pulse_pdn();
    xfer(0, 12'h000, 0, 0, 1, 32'h0, "R8 sticky blocks debugger");
    xfer(1, A_LOCK, KEY, 0, 1, 32'h0, "R8 sticky blocks lock write");
    xfer(0, A_LOCK, 0, 1, 0, 32'h0, "R8 blocked lock write had no effect");
    xfer(0, A_STAT, 0, 0, 0, 32'h1, "R8 status read shows sticky");
    xfer(0, A_STAT, 0, 0, 0, 32'h0, "R8 sticky cleared");
    xfer(0, 12'h000, 0, 0, 0, 32'hA000_0000, "R8 debugger access restored");

    // R7 core off
    @(posedge clk); #1 core_off = 1;
    xfer(0, 12'h000, 0, 1, 1, 32'h0, "R7 privileged read errors");
    xfer(1, 12'h000, 32'hDEAD_0000, 1, 1, 32'h0, "R7 privileged write errors");
    xfer(0, A_STAT, 0, 0, 1, 32'h0, "R7 status errors");
    xfer(0, 12'h200, 0, 0, 0, 32'h0, "R9 unmapped during core off");
    @(posedge clk); #1 core_off = 0;
    xfer(0, 12'h000, 0, 0, 0, 32'hA000_0000, "R7 write had no effect");

    // R5 restore
    xfer(1, A_LOCK, KEY, 1, 0, 32'h0, "R5 lock for restore");
    xfer(1, A_PORT, 32'd3, 1, 0, 32'h0, "R5 wrong count");
    xfer(1, A_PORT, 32'h11, 1, 0, 32'h0, "R5 wrong count again");
    xfer(1, A_PORT, NREG, 1, 0, 32'h0, "R5 correct count");
    for (int i = 0; i < NREG; i++)
      xfer(1, A_PORT, 32'hB000_0000 + i, 1, 0, 32'h0, "R5 restore word");
    xfer(1, A_PORT, 32'hC9C9_C9C9, 1, 0, 32'h0, "R5 extra write");
    xfer(0, A_PORT, 0, 1, 0, 32'h0, "R5 port exhausted");
    xfer(1, A_LOCK, 32'h0, 1, 0, 32'h0, "R5 unlock");
    for (int i = 0; i < NREG; i++)
      xfer(0, AW'(4*i), 0, 0, 0, 32'hB000_0000 + i, "R5 restored word");

    // R9 unmapped
    xfer(0, 12'h3F0, 0, 0, 0, 32'h0, "R9 unmapped read");
    xfer(1, 12'h3F0, 32'hFFFF_FFFF, 0, 0, 32'h0, "R9 unmapped write");

    repeat (3) @(posedge clk);
    if (q_err.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: got %0d pending expected 0", q_err.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule